// File: doc/BRIEF.md
# AXI4 Write-Path Width Downsizer

This block joins a wide AXI4 write master to a narrower AXI4 write slave. It covers the address, data and response channels of the write path. It accepts one INCR write request at a time on the wide side and replays it on the narrow side. When the requested beat size fits the narrow bus, the request is forwarded with its size and length untouched. When the requested beat size is wider than the narrow bus, the size is cut to the full narrow width. The length is scaled up so that every wide beat becomes a run of narrow beats.

A scaled length can go past the 256-beat limit of one AXI4 burst. In that case the block emits a chain of back-to-back bursts, each at most 256 beats long. Every wide data beat is cut into narrow slices by byte address, and each slice keeps its own strobe bits, so no byte ever changes lane order. The narrow slave returns one response per burst. These responses are folded into a single response for the wide master.

Reset is synchronous and active low. The wide bus must be a power-of-two multiple (at least two) of the narrow bus. A request whose size is larger than the narrow bus must start on an address aligned to that size.

Top module: `axi_write_downsizer`

## Requirements
- R1: When s_awsize is at most log2(NARROW_W/8), exactly one narrow burst is issued, with m_awsize equal to s_awsize, m_awlen equal to s_awlen and m_awaddr equal to s_awaddr.
- R2: When s_awsize exceeds log2(NARROW_W/8) = N, m_awsize is N. The total narrow beat count is (s_awlen+1) shifted left by (s_awsize - N).
- R3: A total beat count T is issued as ceil(T/256) consecutive bursts. Each burst except the last has m_awlen 255, and the last carries the remainder. Each burst's m_awaddr equals the previous burst's address plus 256 times the narrow width in bytes, or the request address for the first burst. The address stays stable while m_awvalid waits for m_awready.
- R4: Every generated burst repeats the request's ID, user, burst type, PROT, CACHE, QOS, REGION and LOCK values.
- R5: A narrow beat at byte address A carries bits of wide slice k = A[log2(WIDE_W/8)-1 : N], that is wdata[k*NARROW_W +: NARROW_W], with strobe bits wstrb[k*NARROW_W/8 +: NARROW_W/8].
  - Slices leave in rising address order.
  - A steps by 2^m_awsize from A aligned down to that size.
  - A wide beat is accepted only with its final slice.
- R6: m_wlast is high exactly on the last beat of each narrow burst.
- R7: s_bvalid rises only after the response of the last narrow burst has been accepted.
- R8: s_bresp is the numerically largest m_bresp code seen over all bursts of the request, ranked DECERR=3 > SLVERR=2 > EXOKAY=1 > OKAY=0. s_bid equals the request ID, and exactly one response is returned per request.
- R9: s_awready is low from the cycle after a request is accepted until its merged response has been accepted. It is high again in the next cycle.
- R10: During and right after reset (rst_n low), s_awready is 1 and m_awvalid, m_wvalid, m_bready and s_bvalid are 0.
- R11: s_wlast has no effect. Narrow beat count and m_wlast follow only the request length and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awvalid | input | 1 | Wide-side write address valid |
| s_awready | output | 1 | Wide-side write address ready |
| s_awaddr | input | ADDR_W | Request start address |
| s_awlen | input | 8 | Request beats minus one |
| s_awsize | input | 3 | Request beat size code |
| s_awburst | input | 2 | Burst type (INCR expected) |
| s_awid | input | ID_W | Request ID |
| s_awuser | input | USER_W | Request user field |
| s_awprot | input | 3 | Protection attributes |
| s_awcache | input | 4 | Cache attributes |
| s_awqos | input | 4 | Quality of service |
| s_awregion | input | 4 | Region identifier |
| s_awlock | input | 1 | Lock type |
| s_wvalid | input | 1 | Wide write data valid |
| s_wready | output | 1 | Wide write data ready |
| s_wdata | input | WIDE_W | Wide write data |
| s_wstrb | input | WIDE_W/8 | Wide write strobes |
| s_wlast | input | 1 | Wide last flag (unused) |
| s_bvalid | output | 1 | Merged response valid |
| s_bready | input | 1 | Merged response ready |
| s_bresp | output | 2 | Merged response code |
| s_bid | output | ID_W | Merged response ID |
| m_awvalid | output | 1 | Narrow write address valid |
| m_awready | input | 1 | Narrow write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Burst beats minus one |
| m_awsize | output | 3 | Burst beat size code |
| m_awburst | output | 2 | Burst type |
| m_awid | output | ID_W | Burst ID |
| m_awuser | output | USER_W | Burst user field |
| m_awprot | output | 3 | Protection attributes |
| m_awcache | output | 4 | Cache attributes |
| m_awqos | output | 4 | Quality of service |
| m_awregion | output | 4 | Region identifier |
| m_awlock | output | 1 | Lock type |
| m_wvalid | output | 1 | Narrow write data valid |
| m_wready | input | 1 | Narrow write data ready |
| m_wdata | output | NARROW_W | Narrow write data |
| m_wstrb | output | NARROW_W/8 | Narrow write strobes |
| m_wlast | output | 1 | Last beat of a narrow burst |
| m_bvalid | input | 1 | Narrow response valid |
| m_bready | output | 1 | Narrow response ready |
| m_bresp | input | 2 | Narrow response code |
| m_bid | input | ID_W | Narrow response ID (unused) |

## Verification
A corrupted walking address shows up on the very next narrow beat as data drawn from the wrong slice, and at the next burst boundary as a wrong m_awaddr. A wrong remaining-beat count shows up at the next address phase as a wrong m_awlen, or as a response returned too early. A slice counter that is off by one accepts a wide beat early. The following narrow beats then carry the next wide word's bytes, which the per-beat data check catches within one beat. A response accumulator that is not cleared or not merged shows up only at the end of a request, in s_bresp, so the bench mixes error codes across bursts.

// File: rtl/dsz_pkg.sv
package dsz_pkg;

    localparam int unsigned DSZ_BURST_MAX = 256;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_REPLY
    } dsz_state_e;

    // Request attributes copied unchanged into every narrow burst
    typedef struct packed {
        logic [1:0] burst;
        logic [2:0] prot;
        logic [3:0] cache;
        logic [3:0] qos;
        logic [3:0] region;
        logic       lock;
    } dsz_attr_t;

    // Response ranking: a larger code is the more severe one
    function automatic logic [1:0] dsz_worse(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] dsz_cap_size(input logic [2:0] req, input logic [2:0] cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/dsz_req_capture.sv
module dsz_req_capture
    import dsz_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned USER_W = 2,
    parameter int unsigned NLOG   = 2,
    parameter int unsigned RL     = 2,
    parameter int unsigned CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [7:0]        len_i,
    input  logic [2:0]        size_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [USER_W-1:0] user_i,
    input  dsz_attr_t         attr_i,
    output logic [CNT_W-1:0]  total_o,
    output logic [2:0]        osize_q,
    output logic [RL-1:0]     kmax_q,
    output logic [ID_W-1:0]   id_q,
    output logic [USER_W-1:0] user_q,
    output dsz_attr_t         attr_q
);

    logic [2:0]    osize_d;
    logic [2:0]    shift_d;
    logic [RL:0]   span_d;
    logic [RL-1:0] kmax_d;

    assign osize_d = dsz_cap_size(size_i, 3'(NLOG));
    assign shift_d = size_i - osize_d;
    assign span_d  = (RL+1)'(1) << shift_d;
    assign kmax_d  = RL'(span_d - (RL+1)'(1));
    assign total_o = (CNT_W'(len_i) + CNT_W'(1)) << shift_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osize_q <= '0;
            kmax_q  <= '0;
            id_q    <= '0;
            user_q  <= '0;
            attr_q  <= '0;
        end else if (load_i) begin
            osize_q <= osize_d;
            kmax_q  <= kmax_d;
            id_q    <= id_i;
            user_q  <= user_i;
            attr_q  <= attr_i;
        end
    end

endmodule

// File: rtl/dsz_lane_select.sv
module dsz_lane_select #(
    parameter int unsigned WIDE_W   = 128,
    parameter int unsigned NARROW_W = 32
) (
    input  logic [WIDE_W-1:0]            wdata_i,
    input  logic [WIDE_W/8-1:0]          wstrb_i,
    input  logic [$clog2(WIDE_W/NARROW_W)-1:0] sel_i,
    output logic [NARROW_W-1:0]          ndata_o,
    output logic [NARROW_W/8-1:0]        nstrb_o
);

    localparam int unsigned RATIO = WIDE_W / NARROW_W;
    localparam int unsigned NBYTE = NARROW_W / 8;

    logic [NARROW_W-1:0] dslice [RATIO];
    logic [NBYTE-1:0]    sslice [RATIO];

    for (genvar g = 0; g < RATIO; g++) begin : g_slice
        assign dslice[g] = wdata_i[g*NARROW_W +: NARROW_W];
        assign sslice[g] = wstrb_i[g*NBYTE +: NBYTE];
    end

    assign ndata_o = dslice[sel_i];
    assign nstrb_o = sslice[sel_i];

endmodule

// File: rtl/dsz_resp_merge.sv
module dsz_resp_merge
    import dsz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       take_i,
    input  logic [1:0] resp_i,
    output logic [1:0] resp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       resp_q <= 2'b00;
        else if (clear_i) resp_q <= 2'b00;
        else if (take_i)  resp_q <= dsz_worse(resp_q, resp_i);
    end

endmodule

// File: rtl/axi_write_downsizer.sv
module axi_write_downsizer
    import dsz_pkg::*;
#(
    parameter int unsigned WIDE_W   = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned ID_W     = 4,
    parameter int unsigned USER_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic [7:0]            s_awlen,
    input  logic [2:0]            s_awsize,
    input  logic [1:0]            s_awburst,
    input  logic [ID_W-1:0]       s_awid,
    input  logic [USER_W-1:0]     s_awuser,
    input  logic [2:0]            s_awprot,
    input  logic [3:0]            s_awcache,
    input  logic [3:0]            s_awqos,
    input  logic [3:0]            s_awregion,
    input  logic                  s_awlock,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    input  logic [WIDE_W-1:0]     s_wdata,
    input  logic [WIDE_W/8-1:0]   s_wstrb,
    input  logic                  s_wlast,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    output logic [1:0]            s_bresp,
    output logic [ID_W-1:0]       s_bid,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [7:0]            m_awlen,
    output logic [2:0]            m_awsize,
    output logic [1:0]            m_awburst,
    output logic [ID_W-1:0]       m_awid,
    output logic [USER_W-1:0]     m_awuser,
    output logic [2:0]            m_awprot,
    output logic [3:0]            m_awcache,
    output logic [3:0]            m_awqos,
    output logic [3:0]            m_awregion,
    output logic                  m_awlock,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    output logic [NARROW_W-1:0]   m_wdata,
    output logic [NARROW_W/8-1:0] m_wstrb,
    output logic                  m_wlast,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    input  logic [1:0]            m_bresp,
    input  logic [ID_W-1:0]       m_bid
);

    localparam int unsigned WBYTE = WIDE_W / 8;
    localparam int unsigned NBYTE = NARROW_W / 8;
    localparam int unsigned WLOG  = $clog2(WBYTE);
    localparam int unsigned NLOG  = $clog2(NBYTE);
    localparam int unsigned RL    = WLOG - NLOG;
    localparam int unsigned CNT_W = 9 + RL;

    dsz_state_e         state_q, state_d;
    logic [ADDR_W-1:0]  naddr_q;
    logic [CNT_W-1:0]   rem_q;
    logic [7:0]         blen_q;
    logic [7:0]         bcnt_q;
    logic [RL-1:0]      kcnt_q;

    logic [CNT_W-1:0]   total_w;
    logic [2:0]         osize_w;
    logic [RL-1:0]      kmax_w;
    logic [ID_W-1:0]    id_w;
    logic [USER_W-1:0]  user_w;
    dsz_attr_t          attr_in, attr_w;
    logic [1:0]         merged_w;

    logic               aw_take;
    logic               w_fire;
    logic               slice_end;
    logic               sub_last;
    logic               b_take;
    logic [ADDR_W-1:0]  step_w;
    logic [ADDR_W-1:0]  naddr_next;
    logic [7:0]         len_out;
    logic               unused_inputs;

    assign unused_inputs = ^{s_wlast, m_bid};

    assign attr_in = '{burst: s_awburst, prot: s_awprot, cache: s_awcache,
                       qos: s_awqos, region: s_awregion, lock: s_awlock};

    dsz_req_capture #(
        .ID_W   (ID_W),
        .USER_W (USER_W),
        .NLOG   (NLOG),
        .RL     (RL),
        .CNT_W  (CNT_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (aw_take),
        .len_i   (s_awlen),
        .size_i  (s_awsize),
        .id_i    (s_awid),
        .user_i  (s_awuser),
        .attr_i  (attr_in),
        .total_o (total_w),
        .osize_q (osize_w),
        .kmax_q  (kmax_w),
        .id_q    (id_w),
        .user_q  (user_w),
        .attr_q  (attr_w)
    );

    dsz_lane_select #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_lanes (
        .wdata_i (s_wdata),
        .wstrb_i (s_wstrb),
        .sel_i   (naddr_q[WLOG-1:NLOG]),
        .ndata_o (m_wdata),
        .nstrb_o (m_wstrb)
    );

    dsz_resp_merge u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (aw_take),
        .take_i  (b_take),
        .resp_i  (m_bresp),
        .resp_q  (merged_w)
    );

    // Handshake qualifiers
    assign aw_take    = (state_q == ST_IDLE) && s_awvalid;
    assign slice_end  = (kcnt_q == kmax_w);
    assign sub_last   = (bcnt_q == blen_q);
    assign w_fire     = m_wvalid && m_wready;
    assign b_take     = (state_q == ST_RESP) && m_bvalid;

    // Narrow address walk: align to the beat size, then step one beat
    assign step_w     = ADDR_W'(1) << osize_w;
    assign naddr_next = (naddr_q & ~(step_w - ADDR_W'(1))) + step_w;
    assign len_out    = (rem_q > CNT_W'(DSZ_BURST_MAX)) ? 8'hFF : 8'(rem_q - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (s_awvalid)          state_d = ST_ADDR;
            ST_ADDR:  if (m_awready)          state_d = ST_DATA;
            ST_DATA:  if (w_fire && sub_last) state_d = ST_RESP;
            ST_RESP:  if (m_bvalid)           state_d = (rem_q == '0) ? ST_REPLY : ST_ADDR;
            ST_REPLY: if (s_bready)           state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            naddr_q <= '0;
            rem_q   <= '0;
            blen_q  <= '0;
            bcnt_q  <= '0;
            kcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (aw_take) begin
                naddr_q <= s_awaddr;
                rem_q   <= total_w;
                kcnt_q  <= '0;
            end
            if ((state_q == ST_ADDR) && m_awready) begin
                blen_q <= len_out;
                bcnt_q <= '0;
            end
            if (w_fire) begin
                naddr_q <= naddr_next;
                rem_q   <= rem_q - CNT_W'(1);
                bcnt_q  <= bcnt_q + 8'd1;
                kcnt_q  <= slice_end ? '0 : kcnt_q + RL'(1);
            end
        end
    end

    // Wide side
    assign s_awready  = (state_q == ST_IDLE);
    assign s_wready   = (state_q == ST_DATA) && m_wready && slice_end;
    assign s_bvalid   = (state_q == ST_REPLY);
    assign s_bresp    = merged_w;
    assign s_bid      = id_w;

    // Narrow side
    assign m_awvalid  = (state_q == ST_ADDR);
    assign m_awaddr   = naddr_q;
    assign m_awlen    = len_out;
    assign m_awsize   = osize_w;
    assign m_awburst  = attr_w.burst;
    assign m_awid     = id_w;
    assign m_awuser   = user_w;
    assign m_awprot   = attr_w.prot;
    assign m_awcache  = attr_w.cache;
    assign m_awqos    = attr_w.qos;
    assign m_awregion = attr_w.region;
    assign m_awlock   = attr_w.lock;
    assign m_wvalid   = (state_q == ST_DATA) && s_wvalid;
    assign m_wlast    = sub_last;
    assign m_bready   = (state_q == ST_RESP);

endmodule

// File: rtl/dsz_checker.sv
module dsz_checker #(
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned ADDR_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [1:0]        s_bresp,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic [7:0]        m_awlen,
    input logic [2:0]        m_awsize,
    input logic              m_wvalid
);

    localparam int unsigned NLOG = $clog2(NARROW_W / 8);

    // R9: the request channel closes once a request is taken
    a_r9_aw_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> !s_awready);

    // R9: no new request while the merged response is pending
    a_r9_no_aw_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready);

    // R2: generated bursts never exceed the narrow bus size
    a_r2_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awsize <= 3'(NLOG)));

    // R3: a pending narrow address holds still
    a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)
                                       && $stable(m_awlen) && $stable(m_awsize)));

    // R3: data of a burst never overlaps its own address phase
    a_r3_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> !m_awvalid);

    // R8: one merged response per request
    a_r8_b_once: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && s_bready) |=> !s_bvalid);

    // R8: merged response holds until accepted
    a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

endmodule

bind axi_write_downsizer dsz_checker #(
    .NARROW_W (NARROW_W),
    .ADDR_W   (ADDR_W)
) u_dsz_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awaddr  (m_awaddr),
    .m_awlen   (m_awlen),
    .m_awsize  (m_awsize),
    .m_wvalid  (m_wvalid)
);

// File: tb/tb_axi_write_downsizer.sv
`timescale 1ns/1ps
module tb_axi_write_downsizer;

    localparam int WIDE_W   = 128;
    localparam int NARROW_W = 32;
    localparam int ADDR_W   = 32;
    localparam int ID_W     = 4;
    localparam int USER_W   = 2;
    localparam int NB       = NARROW_W / 8;
    localparam int NLOG     = $clog2(NB);
    localparam int RATIO    = WIDE_W / NARROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                  s_awvalid = 0, s_awready;
    logic [ADDR_W-1:0]     s_awaddr = 0;
    logic [7:0]            s_awlen = 0;
    logic [2:0]            s_awsize = 0;
    logic [1:0]            s_awburst = 2'b01;
    logic [ID_W-1:0]       s_awid = 0;
    logic [USER_W-1:0]     s_awuser = 0;
    logic [2:0]            s_awprot = 0;
    logic [3:0]            s_awcache = 0, s_awqos = 0, s_awregion = 0;
    logic                  s_awlock = 0;
    logic                  s_wvalid = 0, s_wready;
    logic [WIDE_W-1:0]     s_wdata = 0;
    logic [WIDE_W/8-1:0]   s_wstrb = 0;
    logic                  s_wlast = 0;
    logic                  s_bvalid, s_bready = 0;
    logic [1:0]            s_bresp;
    logic [ID_W-1:0]       s_bid;
    logic                  m_awvalid, m_awready = 0;
    logic [ADDR_W-1:0]     m_awaddr;
    logic [7:0]            m_awlen;
    logic [2:0]            m_awsize;
    logic [1:0]            m_awburst;
    logic [ID_W-1:0]       m_awid;
    logic [USER_W-1:0]     m_awuser;
    logic [2:0]            m_awprot;
    logic [3:0]            m_awcache, m_awqos, m_awregion;
    logic                  m_awlock;
    logic                  m_wvalid, m_wready = 0;
    logic [NARROW_W-1:0]   m_wdata;
    logic [NARROW_W/8-1:0] m_wstrb;
    logic                  m_wlast;
    logic                  m_bvalid = 0, m_bready;
    logic [1:0]            m_bresp = 0;
    logic [ID_W-1:0]       m_bid = 0;

    axi_write_downsizer #(
        .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .USER_W(USER_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
        .s_awsize(s_awsize), .s_awburst(s_awburst), .s_awid(s_awid), .s_awuser(s_awuser),
        .s_awprot(s_awprot), .s_awcache(s_awcache), .s_awqos(s_awqos), .s_awregion(s_awregion),
        .s_awlock(s_awlock),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_wlast(s_wlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp), .s_bid(s_bid),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awid(m_awid), .m_awuser(m_awuser),
        .m_awprot(m_awprot), .m_awcache(m_awcache), .m_awqos(m_awqos), .m_awregion(m_awregion),
        .m_awlock(m_awlock),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp), .m_bid(m_bid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [WIDE_W-1:0]   wd [256];
    logic [WIDE_W/8-1:0] ws [256];
    logic [1:0]          brs [8];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // rmode: 0 random codes, 1 all OKAY, 2 fixed mix with DECERR in burst 2
    task automatic run_txn(input logic [31:0] addr, input int len, input int size, input int rmode);
        int osz, diff, total, nbur, step;
        logic [1:0] worst;
        logic [ID_W-1:0] id;
        logic [USER_W-1:0] usr;
        logic [2:0] prot;
        logic [3:0] cache, qos, region;
        logic lock;
        osz   = (size > NLOG) ? NLOG : size;
        diff  = size - osz;
        total = (len + 1) << diff;
        nbur  = (total + 255) / 256;
        step  = 1 << osz;
        worst = 2'b00;
        for (int j = 0; j < nbur; j++) begin
            if (rmode == 0)      brs[j] = 2'($urandom % 4);
            else if (rmode == 1) brs[j] = 2'b00;
            else                 brs[j] = (j == 2) ? 2'b11 : ((j == 1) ? 2'b10 : 2'b01);
            if (brs[j] > worst) worst = brs[j];
        end
        for (int w = 0; w <= len; w++) begin
            for (int q = 0; q < WIDE_W/32; q++) wd[w][q*32 +: 32] = $urandom;
            ws[w] = (WIDE_W/8)'($urandom);
        end
        id = ID_W'($urandom); usr = USER_W'($urandom); prot = 3'($urandom);
        cache = 4'($urandom); qos = 4'($urandom); region = 4'($urandom); lock = 1'($urandom);

        @(negedge clk);
        s_awvalid = 1; s_awaddr = addr; s_awlen = 8'(len); s_awsize = 3'(size);
        s_awid = id; s_awuser = usr; s_awprot = prot; s_awcache = cache;
        s_awqos = qos; s_awregion = region; s_awlock = lock;
        forever begin #1; if (s_awready) break; @(negedge clk); end
        @(negedge clk);
        s_awvalid = 0;

        fork
            begin : wide_driver
                for (int w = 0; w <= len; w++) begin
                    forever begin
                        @(negedge clk);
                        s_wvalid = ($urandom % 4) != 0;
                        s_wdata  = wd[w];
                        s_wstrb  = ws[w];
                        s_wlast  = 1'($urandom); // R11: noise on the wide last flag
                        #1;
                        if (s_wvalid && s_wready) break;
                    end
                end
                @(negedge clk);
                s_wvalid = 0;
            end
            begin : narrow_slave
                logic [31:0] a;
                int n;
                a = addr;
                n = 0;
                for (int j = 0; j < nbur; j++) begin
                    int blen, sel, widx;
                    blen = ((total - 256*j) > 256) ? 255 : (total - 256*j - 1);
                    forever begin
                        @(negedge clk);
                        m_awready = ($urandom % 3) == 0;
                        #1;
                        if (m_awvalid && m_awready) break;
                    end
                    chk(m_awaddr == a, "R3 burst address", m_awaddr, a);
                    chk(m_awlen == 8'(blen), "R1 R2 R3 burst length", m_awlen, blen);
                    chk(m_awsize == 3'(osz), "R1 R2 burst size", m_awsize, osz);
                    chk({m_awid, m_awuser, m_awprot, m_awcache, m_awqos, m_awregion, m_awlock, m_awburst}
                        == {id, usr, prot, cache, qos, region, lock, 2'b01},
                        "R4 copied attributes",
                        {m_awid, m_awuser, m_awprot, m_awcache, m_awqos, m_awregion, m_awlock, m_awburst},
                        {id, usr, prot, cache, qos, region, lock, 2'b01});
                    chk(!s_awready && !s_bvalid, "R9 R7 wide side quiet mid-request",
                        {s_awready, s_bvalid}, 2'b00);
                    @(negedge clk);
                    m_awready = 0;
                    for (int b = 0; b <= blen; b++) begin
                        forever begin
                            @(negedge clk);
                            m_wready = ($urandom % 2) == 0;
                            #1;
                            if (m_wvalid && m_wready) break;
                        end
                        widx = n >> diff;
                        sel  = (a >> NLOG) % RATIO;
                        chk(m_wdata == wd[widx][sel*NARROW_W +: NARROW_W], "R5 slice data",
                            m_wdata, wd[widx][sel*NARROW_W +: NARROW_W]);
                        chk(m_wstrb == ws[widx][sel*NB +: NB], "R5 slice strobe",
                            m_wstrb, ws[widx][sel*NB +: NB]);
                        chk(m_wlast == (b == blen), "R6 R11 narrow last", m_wlast, (b == blen));
                        a = (a & ~(step - 1)) + step;
                        n++;
                    end
                    @(negedge clk);
                    m_wready = 0;
                    m_bvalid = 1;
                    m_bresp  = brs[j];
                    m_bid    = ID_W'($urandom);
                    forever begin #1; if (m_bready) break; @(negedge clk); end
                    @(negedge clk);
                    m_bvalid = 0;
                end
            end
        join

        forever begin @(negedge clk); #1; if (s_bvalid) break; end
        chk(s_bresp == worst, "R8 merged response", s_bresp, worst);
        chk(s_bid == id, "R8 response id", s_bid, id);
        repeat ($urandom % 3) begin
            @(negedge clk); #1;
            chk(s_bvalid && !s_awready, "R9 hold while response pending", {s_bvalid, s_awready}, 2'b10);
        end
        @(negedge clk);
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
        #1;
        chk(s_awready && !s_bvalid, "R9 R8 reopen after response", {s_awready, s_bvalid}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(s_awready && !m_awvalid && !m_wvalid && !m_bready && !s_bvalid, "R10 reset state",
            {s_awready, m_awvalid, m_wvalid, m_bready, s_bvalid}, 5'b10000);
        rst_n = 1;
        @(negedge clk);
        chk(s_awready && !m_awvalid && !s_bvalid, "R10 after release",
            {s_awready, m_awvalid, s_bvalid}, 3'b100);

        run_txn(32'h0000_1000, 63, 4, 1);   // R2: exactly 256 beats, one burst
        run_txn(32'h0000_2000, 64, 4, 0);   // R3: 256 + 4
        run_txn(32'h0001_0000, 255, 4, 2);  // R3 R8: four bursts, DECERR wins
        run_txn(32'h0000_3008, 200, 3, 0);  // R2 R3: 256 + 146
        run_txn(32'h0000_4004, 255, 2, 0);  // R1: full-width pass-through
        run_txn(32'h0000_500A, 5, 1, 0);    // R1 R5: halfword, unaligned slices
        run_txn(32'h0000_6003, 7, 0, 0);    // R1 R5: byte beats across lanes
        run_txn(32'h0000_7000, 0, 4, 1);    // single wide beat
        for (int t = 0; t < 30; t++) begin
            int sz, ln;
            logic [31:0] ad;
            sz = $urandom % 5;
            ln = (($urandom % 4) == 0) ? ($urandom % 256) : ($urandom % 40);
            ad = $urandom & 32'h00FF_FFFF;
            if (sz > NLOG) ad = ad & ~((32'd1 << sz) - 1);
            run_txn(ad, ln, sz, 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule